// File: doc/BRIEF.md
# Serial-In Latched Segment Driver Core

This block is the digital core of a chainable serial-to-parallel driver for segmented electroluminescent, piezo or tactile loads. A host shifts segment data in one bit per rising edge of a slow serial clock. A level-sensitive, active-low load input then passes the shifted word to a parallel output latch. While the load input is high, the latch holds the word, so new data can be shifted in without disturbing the segments.

A polarity input sets the sense of every segment output and drives a backplane line that is always its complement. Toggling polarity therefore drives the segments with AC against the backplane. The last shift stage is retimed on the falling serial clock edge and appears on a cascade output, which feeds the data input of the next device in a chain.

All logic runs in one fast system clock domain. The serial clock, serial data, load and polarity inputs pass through a two-flop synchronizer, and serial clock edges are found by comparing consecutive synchronized samples. Each serial clock phase must therefore last at least three system clock cycles.

Top module: `seg_drv_top`

## Requirements
- R1: While reset is asserted and in the cycle after it ends, all segment outputs, the backplane output and the cascade output are 0. This holds when the load input is held high and polarity is held high during reset.
- R2: On each rising edge of the serial clock, the shift register moves up one position and stage 1 (bit 0) takes the serial data input. After 16 edges, the first bit shifted in sits in stage 16 (bit 15), which maps to segment output 15.
- R3: While the load input is low, the output latch follows the shift register, so the segment outputs track each shift.
- R4: While the load input is high, the output latch keeps its value even as shifting goes on.
- R5: With polarity high, each segment output equals its latched bit and the backplane output is 0.
- R6: With polarity low, each segment output is the complement of its latched bit and the backplane output is 1.
- R7: The cascade output takes the value of stage 16 only on a falling edge of the serial clock. It keeps its old value across the rising edge that shifts the register.
- R8: Changes on the serial data input while the serial clock is steady have no effect on the shift register, the latch or any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sclk_in | input | 1 | Serial shift clock, asynchronous to clk |
| sdata_in | input | 1 | Serial data input |
| load_n_in | input | 1 | Active-low latch load: low makes the latch transparent |
| pol_in | input | 1 | Polarity: high passes latched bits, low inverts them |
| seg_out | output | NSEG | Segment outputs, bit 15 is the last shift stage |
| bp_out | output | 1 | Backplane output, the complement of polarity |
| casc_out | output | 1 | Cascade serial output, retimed on the falling serial clock edge |

## Verification
On every cycle, the assertions check how each register relates to its synchronized inputs: bit 0 takes the data on a rising edge, the register and the cascade output stay stable when there is no edge, the cascade output samples stage 16 on a falling edge, the latch freezes or follows with the load input, and the segment and backplane outputs follow polarity. Only the bench scenarios can show the end-to-end behaviour. These include the bit order after a full 16-bit load, the cascade value seen between the rising and falling edges, the frozen segments during a shift with load high, the inverted output after a polarity swap, and the reset values.

// File: rtl/seg_drv_pkg.sv
package seg_drv_pkg;
  localparam int SD_SYNC_DEPTH = 2;

  typedef struct packed {
    logic sclk;
    logic sdata;
    logic load_n;
    logic pol;
  } sd_ctl_t;

  localparam int SD_CTL_W = $bits(sd_ctl_t);

  // Synchronizer reset image: load held off, polarity non-inverting
  localparam sd_ctl_t SD_CTL_RST = '{sclk: 1'b0, sdata: 1'b0, load_n: 1'b1, pol: 1'b1};
endpackage

// File: rtl/sdrv_sync.sv
module sdrv_sync #(
  parameter int W = 4,
  parameter int DEPTH = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage_q [DEPTH];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) stage_q[i] <= RST_VAL;
    end else begin
      stage_q[0] <= d;
      for (int i = 1; i < DEPTH; i++) stage_q[i] <= stage_q[i-1];
    end
  end

  assign q = stage_q[DEPTH-1];
endmodule

// File: rtl/sdrv_shift.sv
module sdrv_shift #(
  parameter int N = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         sclk_s,
  input  logic         sdata_s,
  output logic [N-1:0] stages,
  output logic         casc
);
  logic sclk_d;
  logic rise, fall;

  assign rise = sclk_s & ~sclk_d;
  assign fall = ~sclk_s & sclk_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_d <= 1'b0;
      stages <= '0;
      casc   <= 1'b0;
    end else begin
      sclk_d <= sclk_s;
      if (rise) stages <= {stages[N-2:0], sdata_s};
      if (fall) casc <= stages[N-1];
    end
  end

  // R2
  shift_entry_chk: assert property (@(posedge clk) disable iff (rst)
    rise |=> stages[0] == $past(sdata_s));

  // R8
  shift_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !rise |=> $stable(stages));

  // R7
  casc_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !fall |=> $stable(casc));

  // R7
  casc_sample_chk: assert property (@(posedge clk) disable iff (rst)
    fall |=> casc == $past(stages[N-1]));
endmodule

// File: rtl/sdrv_latch.sv
module sdrv_latch #(
  parameter int N = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load_n_s,
  input  logic         pol_s,
  input  logic [N-1:0] stages,
  output logic [N-1:0] seg,
  output logic         bp
);
  logic [N-1:0] latch_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      latch_q <= '0;
      seg     <= '0;
      bp      <= 1'b0;
    end else begin
      if (!load_n_s) latch_q <= stages;
      seg <= pol_s ? latch_q : ~latch_q;
      bp  <= ~pol_s;
    end
  end

  // R4
  latch_freeze_chk: assert property (@(posedge clk) disable iff (rst)
    load_n_s |=> $stable(latch_q));

  // R3
  latch_follow_chk: assert property (@(posedge clk) disable iff (rst)
    !load_n_s |=> latch_q == $past(stages));

  // R5
  pol_pass_chk: assert property (@(posedge clk) disable iff (rst)
    pol_s |=> (seg == $past(latch_q)) && !bp);

  // R6
  pol_invert_chk: assert property (@(posedge clk) disable iff (rst)
    !pol_s |=> (seg == ~$past(latch_q)) && bp);
endmodule

// File: rtl/seg_drv_top.sv
module seg_drv_top
  import seg_drv_pkg::*;
#(
  parameter int NSEG = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            sclk_in,
  input  logic            sdata_in,
  input  logic            load_n_in,
  input  logic            pol_in,
  output logic [NSEG-1:0] seg_out,
  output logic            bp_out,
  output logic            casc_out
);
  sd_ctl_t ctl_raw, ctl_s;
  logic [NSEG-1:0] stages;

  assign ctl_raw = '{sclk: sclk_in, sdata: sdata_in, load_n: load_n_in, pol: pol_in};

  sdrv_sync #(
    .W(SD_CTL_W),
    .DEPTH(SD_SYNC_DEPTH),
    .RST_VAL(SD_CTL_RST)
  ) u_sync (
    .clk(clk),
    .rst(rst),
    .d(ctl_raw),
    .q(ctl_s)
  );

  sdrv_shift #(.N(NSEG)) u_shift (
    .clk(clk),
    .rst(rst),
    .sclk_s(ctl_s.sclk),
    .sdata_s(ctl_s.sdata),
    .stages(stages),
    .casc(casc_out)
  );

  sdrv_latch #(.N(NSEG)) u_latch (
    .clk(clk),
    .rst(rst),
    .load_n_s(ctl_s.load_n),
    .pol_s(ctl_s.pol),
    .stages(stages),
    .seg(seg_out),
    .bp(bp_out)
  );

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    $past(rst) |-> (seg_out == '0) && !bp_out && !casc_out);
endmodule

// File: tb/test_seg_drv_top.sv
module test_seg_drv_top;
  localparam int CLK_PERIOD = 10;
  localparam int N = 16;
  localparam int PH = 6;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sclk = 1'b0, sdata = 1'b0, load_n = 1'b1, pol = 1'b1;
  logic [N-1:0] seg_out;
  logic bp_out, casc_out;

  int n_tests = 0;
  int n_fail = 0;
  bit done = 0;

  typedef struct {
    string tag;
    logic [N-1:0] seg;
    logic bp;
    logic casc;
  } exp_t;
  exp_t exp_q[$];

  logic [N-1:0] m_sr = '0, m_lat = '0;
  logic m_pol = 1'b1, m_load_n = 1'b1, m_casc = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  seg_drv_top #(.NSEG(N)) i_seg_drv_top (
    .clk(clk), .rst(rst), .sclk_in(sclk), .sdata_in(sdata),
    .load_n_in(load_n), .pol_in(pol),
    .seg_out(seg_out), .bp_out(bp_out), .casc_out(casc_out)
  );

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic push_exp(string tag);
    exp_t e;
    e.tag  = tag;
    e.seg  = m_pol ? m_lat : ~m_lat;
    e.bp   = ~m_pol;
    e.casc = m_casc;
    exp_q.push_back(e);
  endtask

  // one serial bit: check mid high phase (cascade still old) and after fall
  task automatic shift_bit(logic b, string tag);
    sdata = b;
    idle(PH);
    sclk = 1'b1;
    m_sr = {m_sr[N-2:0], b};
    if (!m_load_n) m_lat = m_sr;
    idle(PH);
    push_exp(tag);
    sclk = 1'b0;
    m_casc = m_sr[N-1];
    idle(PH);
    push_exp(tag);
  endtask

  task automatic set_load_n(logic v);
    load_n = v;
    m_load_n = v;
    if (!v) m_lat = m_sr;
    idle(PH);
  endtask

  task automatic set_pol(logic v);
    pol = v;
    m_pol = v;
    idle(PH);
  endtask

  // monitor: compares outputs against queued expectations
  initial begin
    exp_t e;
    forever begin
      @(negedge clk);
      if (exp_q.size() > 0) begin
        e = exp_q.pop_front();
        n_tests++;
        if (seg_out !== e.seg || bp_out !== e.bp || casc_out !== e.casc) begin
          n_fail++;
          $display("FAIL %s: seg=%h bp=%b casc=%b expected seg=%h bp=%b casc=%b",
                   e.tag, seg_out, bp_out, casc_out, e.seg, e.bp, e.casc);
        end
      end
    end
  end

  // driver
  initial begin
    logic [N-1:0] pat;
    idle(4);
    push_exp("R1 reset");
    idle(1);
    rst = 1'b0;
    idle(1);
    push_exp("R1 after reset");
    idle(2);

    // R2 R3 R7: transparent load of a full word, first bit to seg 15
    set_load_n(1'b0);
    pat = 16'hA5C3;
    for (int i = N - 1; i >= 0; i--) shift_bit(pat[i], "R2/R3/R7 transparent shift");
    idle(2);
    n_tests++;
    if (seg_out !== pat) begin
      n_fail++;
      $display("FAIL R2 word order: seg=%h expected %h", seg_out, pat);
    end

    // R8: data toggles with serial clock steady
    for (int k = 0; k < 6; k++) begin
      sdata = ~sdata;
      idle(2);
    end
    idle(PH);
    push_exp("R8 data without clock edge");

    // R4: freeze while shifting continues
    set_load_n(1'b1);
    push_exp("R4 freeze entry");
    for (int i = 0; i < 5; i++) shift_bit(i[0], "R4/R7 frozen shift");

    // R3: reopen latch picks up current register
    set_load_n(1'b0);
    push_exp("R3 reopen");

    // R6 then R5
    set_pol(1'b0);
    push_exp("R6 invert");
    set_pol(1'b1);
    push_exp("R5 pass");

    // R6 with frozen latch and shifting
    set_load_n(1'b1);
    set_pol(1'b0);
    for (int i = 0; i < 3; i++) shift_bit(1'b1, "R6/R4 inverted frozen");
    push_exp("R6 bp high");

    wait (exp_q.size() == 0);
    idle(2);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule